// File: doc/BRIEF.md
# Motion Threshold Interrupt Engine

This block watches a stream of three-axis acceleration samples, each a signed 8-bit value per axis delivered with a one-cycle valid strobe. Every axis is compared in magnitude against a programmable 7-bit threshold and reported as either a high event or a low event. The six events are masked by per-event enables and merged into one condition, either by OR (any enabled event) or by AND (every enabled event at once). AND over the low events detects free fall. AND over high events detects a sharp movement on several axes at the same time.

A duration counter qualifies the condition. It counts qualifying samples. The interrupt fires on a qualifying sample that finds the counter at or above a programmed duration. When the condition drops, the counter either clears or steps down by one, depending on a mode bit. The result goes to a source register and the interrupt pin. A small capture state machine has two states, `ST_EMPTY` (nothing held, `irq` low) and `ST_HELD` (flags held, `irq` high). It moves `ST_EMPTY -> ST_HELD` when it accepts a firing sample. It moves `ST_HELD -> ST_EMPTY` on a source read with no capture, or on a non-firing sample in the non-latched mode. It stays `ST_HELD -> ST_HELD` with fresh flags when a firing sample is accepted while already held. In latched mode, samples are accepted only in `ST_EMPTY` or in the cycle of a source read. In non-latched mode, every sample is accepted.

Software reaches four byte registers through a simple read/write port. Read data is combinational from the address. A read strobe on the source address clears the source at the next clock edge.

Top module: `motion_irq_engine`

## Requirements
- R1: After reset, `irq` is 0 and all four registers read 0.
- R2: An axis is "high" when its magnitude is strictly greater than the threshold and "low" otherwise. The value -128 has magnitude 128.
- R3: In OR mode (config bit 6 = 0), the condition is true when any enabled event is true.
- R4: In AND mode (config bit 6 = 1), the condition is true only when every enabled event is true. With no event enabled, the condition is never true.
- R5: A qualifying sample fires when the counter, taken before that sample, is at or above the duration register. With a duration of 0, the first qualifying sample fires.
- R6: With threshold bit 7 = 0, a non-qualifying sample clears the counter to 0.
- R7: With threshold bit 7 = 1, a non-qualifying sample decrements the counter by one, stopping at 0.
- R8: The counter moves only on cycles with `smp_valid` high. A qualifying sample increments it, and it saturates at 255.
- R9: The source register reads {0, IA, ZH, ZL, YH, YL, XH, XL} from bit 7 down to bit 0. On a capture, IA = 1 and the other six bits hold the enabled events that were true. `irq` always equals IA.
- R10: A read of address 1 returns the source and then clears both the source and `irq`.
- R11: With config bit 7 = 1 (latched), a captured source is held unchanged, whatever samples arrive, until it is read.
- R12: With config bit 7 = 0, every sample reloads the source. A firing sample loads its flags, and any other sample loads 0.
- R13: When a source read and a firing sample fall in the same cycle, the read returns the old value and the new event is captured after the clear.
- R14: The register map is as follows. Address 0 is config: bits 5..0 enable XL, XH, YL, YH, ZL, ZH; bit 6 selects AND mode; bit 7 selects latched mode. Address 1 is the source, and writes to it are ignored. Address 2 is the threshold: bit 7 selects decrement mode, bits 6..0 hold the value. Address 3 is the duration. Writable registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears source at address 1) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| smp_valid | input | 1 | Sample strobe |
| smp_x | input | 8 | X sample, signed |
| smp_y | input | 8 | Y sample, signed |
| smp_z | input | 8 | Z sample, signed |
| irq | output | 1 | Interrupt, registered |

## Verification
The threshold comparison is driven with the values equal to, one above and the negated value of the threshold, plus -128 against the largest threshold. These separate strict from non-strict comparison and show whether the magnitude is handled correctly. The same sample vectors are sent in OR and AND mode, and with an empty enable set, so that the two combine rules give different answers. A Q Q Q N Q and Q Q Q N Q N N Q series is run in both counter modes, which tells clearing apart from decrementing. A 300-sample run against duration 255 exposes counter wrap-around. Latched runs send a second, different event and a non-firing sample while a value is held, and one run puts a read and a firing sample in the same cycle.

// File: rtl/motion_irq_pkg.sv
package motion_irq_pkg;
    localparam int REG_W  = 8;
    localparam int AXES   = 3;
    localparam int EV_W   = 2 * AXES;

    localparam logic [1:0] ADDR_CFG = 2'd0;
    localparam logic [1:0] ADDR_SRC = 2'd1;
    localparam logic [1:0] ADDR_THS = 2'd2;
    localparam logic [1:0] ADDR_DUR = 2'd3;

    localparam int CFG_AND_BIT   = EV_W;
    localparam int CFG_LATCH_BIT = EV_W + 1;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } src_state_t;
endpackage

// File: rtl/motion_axis_cmp.sv
module motion_axis_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] val,
    input  logic [DATA_W-2:0] ths,
    output logic              ev_hi,
    output logic              ev_lo
);
    // Two's-complement magnitude; the most negative code maps to 2^(DATA_W-1).
    logic [DATA_W-1:0] mag;

    always_comb begin
        mag   = val[DATA_W-1] ? (~val + 1'b1) : val;
        ev_hi = mag > {1'b0, ths};
        ev_lo = !ev_hi;
    end
endmodule

// File: rtl/motion_dur_cnt.sv
module motion_dur_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             cond,
    input  logic             dec_mode,
    input  logic [CNT_W-1:0] dur,
    output logic             fire,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    assign fire = step && cond && (cnt >= dur);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (step) begin
            if (cond) begin
                if (cnt != CNT_MAX) cnt <= cnt + CNT_ONE;
            end else if (dec_mode) begin
                if (cnt != '0) cnt <= cnt - CNT_ONE;
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/motion_src_ctrl.sv
module motion_src_ctrl
    import motion_irq_pkg::*;
#(
    parameter int FLAG_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic              smp_valid,
    input  logic              fire,
    input  logic              rd_clr,
    input  logic [FLAG_W-1:0] flags,
    output logic              irq,
    output logic [FLAG_W:0]   src
);
    src_state_t st_q, st_d;
    logic       take;
    logic [FLAG_W:0] src_d;

    // A sample is accepted unless a latched value is waiting to be read.
    assign take = smp_valid && (!latch_en || (st_q == ST_EMPTY) || rd_clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY: begin
                if (take && fire) st_d = ST_HELD;
            end
            ST_HELD: begin
                if (take)        st_d = fire ? ST_HELD : ST_EMPTY;
                else if (rd_clr) st_d = ST_EMPTY;
            end
        endcase
    end

    always_comb begin
        if (take)        src_d = fire ? {1'b1, flags} : '0;
        else if (rd_clr) src_d = '0;
        else             src_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src <= '0;
        else        src <= src_d;
    end

    assign irq = (st_q == ST_HELD);
endmodule

// File: rtl/motion_irq_engine.sv
module motion_irq_engine
    import motion_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_x,
    input  logic [DATA_W-1:0] smp_y,
    input  logic [DATA_W-1:0] smp_z,
    output logic              irq
);
    localparam int THS_W = DATA_W - 1;
    localparam int CNT_W = DATA_W;

    logic [DATA_W-1:0] cfg_q;
    logic [THS_W-1:0]  ths_q;
    logic              dec_q;
    logic [CNT_W-1:0]  dur_q;

    logic [AXES-1:0][DATA_W-1:0] axis_v;
    logic [EV_W-1:0] ev;
    logic [EV_W-1:0] en;
    logic [EV_W-1:0] matched;
    logic            and_mode;
    logic            latch_en;
    logic            cond;
    logic            fire;
    logic            rd_clr;
    logic [CNT_W-1:0] cnt;
    logic [EV_W:0]   src;

    // Register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ths_q <= '0;
            dec_q <= 1'b0;
            dur_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                ADDR_CFG: cfg_q <= reg_wdata;
                ADDR_THS: {dec_q, ths_q} <= reg_wdata;
                ADDR_DUR: dur_q <= reg_wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CFG: reg_rdata = cfg_q;
            ADDR_SRC: reg_rdata = DATA_W'(src);
            ADDR_THS: reg_rdata = {dec_q, ths_q};
            default:  reg_rdata = dur_q;
        endcase
    end

    assign rd_clr   = reg_re && (reg_addr == ADDR_SRC);
    assign en       = cfg_q[EV_W-1:0];
    assign and_mode = cfg_q[CFG_AND_BIT];
    assign latch_en = cfg_q[CFG_LATCH_BIT];
    assign axis_v   = {smp_z, smp_y, smp_x};

    // Per-axis classification: event bit 2a is low, 2a+1 is high.
    for (genvar a = 0; a < AXES; a++) begin : g_axis
        motion_axis_cmp #(.DATA_W(DATA_W)) u_cmp (
            .val   (axis_v[a]),
            .ths   (ths_q),
            .ev_hi (ev[2*a+1]),
            .ev_lo (ev[2*a])
        );
    end

    always_comb begin
        matched = ev & en;
        if (and_mode) cond = (en != '0) && (matched == en);
        else          cond = |matched;
    end

    motion_dur_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (smp_valid),
        .cond     (cond),
        .dec_mode (dec_q),
        .dur      (dur_q),
        .fire     (fire),
        .cnt      (cnt)
    );

    motion_src_ctrl #(.FLAG_W(EV_W)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .latch_en  (latch_en),
        .smp_valid (smp_valid),
        .fire      (fire),
        .rd_clr    (rd_clr),
        .flags     (matched),
        .irq       (irq),
        .src       (src)
    );
endmodule

// File: rtl/motion_irq_chk.sv
module motion_irq_chk #(
    parameter int CNT_W = 8,
    parameter int SRC_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_clr,
    input logic             smp_valid,
    input logic             irq,
    input logic [SRC_W-1:0] src,
    input logic             latch_en,
    input logic             cond,
    input logic             dec_mode,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R9
    irq_is_ia_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == src[SRC_W-1]);

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !smp_valid) |=> (!irq && src == '0));

    // R11
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && irq && !rd_clr) |=> $stable(src));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && cond && cnt == CNT_MAX) |=> cnt == CNT_MAX);

    // R8
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(cnt));

    // R6
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cond && !dec_mode) |=> cnt == '0);

    // R7
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !cond && dec_mode && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
endmodule

bind motion_irq_engine motion_irq_chk #(.CNT_W(8), .SRC_W(7)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_clr    (rd_clr),
    .smp_valid (smp_valid),
    .irq       (irq),
    .src       (src),
    .latch_en  (latch_en),
    .cond      (cond),
    .dec_mode  (dec_q),
    .cnt       (cnt)
);

// File: tb/motion_irq_engine_tb.sv
module motion_irq_engine_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       smp_valid = 1'b0;
    logic [7:0] smp_x = 8'd0;
    logic [7:0] smp_y = 8'd0;
    logic [7:0] smp_z = 8'd0;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    motion_irq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
        .irq(irq)
    );

    task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_re = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic smp(logic [7:0] x, logic [7:0] y, logic [7:0] z);
        smp_valid = 1'b1; smp_x = x; smp_y = y; smp_z = z;
        @(posedge clk); @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic flush();
        logic [7:0] d;
        wr(2'd0, 8'h00);
        wr(2'd2, 8'd20);
        smp(8'd0, 8'd0, 8'd0);
        rd(2'd1, d);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            chk("R1 reg", d, 8'h00);
        end
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(2'd0, 8'hC5); rd(2'd0, d); chk("R14 cfg", d, 8'hC5);
        wr(2'd2, 8'h94); rd(2'd2, d); chk("R14 ths", d, 8'h94);
        wr(2'd3, 8'h07); rd(2'd3, d); chk("R14 dur", d, 8'h07);
        wr(2'd1, 8'h7F); rd(2'd1, d); chk("R14 src write ignored", d, 8'h00);
        wr(2'd3, 8'h00);
    endtask

    task automatic t_compare();
        logic [7:0] d;
        flush();
        wr(2'd0, 8'h02);
        smp(8'd21, 8'd0, 8'd0);
        chk("R2 above ths irq", {7'd0, irq}, 8'h01);
        rd(2'd1, d); chk("R9 src XH", d, 8'h42);
        chk("R10 irq cleared", {7'd0, irq}, 8'h00);
        rd(2'd1, d); chk("R10 src cleared", d, 8'h00);
        smp(8'd21, 8'd0, 8'd0);
        smp(8'd20, 8'd0, 8'd0);
        chk("R2 R12 equal ths not high", {7'd0, irq}, 8'h00);
        smp(8'hEB, 8'd0, 8'd0);
        chk("R2 negative magnitude", {7'd0, irq}, 8'h01);
        wr(2'd2, 8'h7F);
        smp(8'h80, 8'd0, 8'd0);
        chk("R2 -128 exceeds 127", {7'd0, irq}, 8'h01);
        smp(8'h81, 8'd0, 8'd0);
        chk("R2 -127 not above 127", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_combine();
        logic [7:0] d;
        flush();
        wr(2'd0, 8'h55);
        smp(8'd5, 8'hFB, 8'd20);
        rd(2'd1, d); chk("R4 and all low", d, 8'h55);
        smp(8'd5, 8'd21, 8'd0);
        chk("R4 and one missing", {7'd0, irq}, 8'h00);
        wr(2'd0, 8'h15);
        smp(8'd5, 8'd21, 8'd0);
        rd(2'd1, d); chk("R3 or partial flags", d, 8'h51);
        wr(2'd0, 8'h40);
        smp(8'd0, 8'd0, 8'd0);
        chk("R4 empty enable", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_dur_reset();
        flush();
        wr(2'd0, 8'h02); wr(2'd3, 8'd2);
        smp(8'd30, 0, 0); chk("R5 q1", {7'd0, irq}, 8'h00);
        smp(8'd30, 0, 0); chk("R5 q2", {7'd0, irq}, 8'h00);
        smp(8'd30, 0, 0); chk("R5 q3 fires", {7'd0, irq}, 8'h01);
        smp(8'd0, 0, 0);  chk("R12 drop", {7'd0, irq}, 8'h00);
        smp(8'd30, 0, 0); chk("R6 counter cleared", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_dur_dec();
        flush();
        wr(2'd0, 8'h02); wr(2'd3, 8'd2); wr(2'd2, 8'h94);
        smp(8'd30, 0, 0); smp(8'd30, 0, 0); smp(8'd30, 0, 0);
        smp(8'd0, 0, 0);
        smp(8'd30, 0, 0); chk("R7 decremented keeps fire", {7'd0, irq}, 8'h01);
        smp(8'd0, 0, 0); smp(8'd0, 0, 0);
        smp(8'd30, 0, 0); chk("R7 two decrements", {7'd0, irq}, 8'h00);
        wr(2'd3, 8'd0);
    endtask

    task automatic t_strobe();
        flush();
        wr(2'd0, 8'h02); wr(2'd3, 8'd3);
        smp_x = 8'd50;
        repeat (10) @(negedge clk);
        smp(8'd50, 0, 0);
        chk("R8 idle cycles not counted", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_saturate();
        flush();
        wr(2'd0, 8'h02); wr(2'd3, 8'd255);
        for (int i = 1; i <= 300; i++) begin
            smp(8'd30, 0, 0);
            if (i == 255) chk("R8 R5 before 255", {7'd0, irq}, 8'h00);
            if (i == 256) chk("R8 R5 at 256", {7'd0, irq}, 8'h01);
            if (i == 300) chk("R8 saturated", {7'd0, irq}, 8'h01);
        end
        wr(2'd3, 8'd0);
    endtask

    task automatic t_latch();
        logic [7:0] d;
        flush();
        wr(2'd0, 8'h8A); wr(2'd3, 8'd0);
        smp(8'd30, 8'd0, 0);
        smp(8'd0, 8'd30, 0);
        smp(8'd0, 8'd0, 0);
        chk("R11 irq held", {7'd0, irq}, 8'h01);
        rd(2'd1, d); chk("R11 first event kept", d, 8'h42);
        chk("R10 latched cleared", {7'd0, irq}, 8'h00);
        smp(8'd30, 8'd0, 0);
        reg_re = 1'b1; reg_addr = 2'd1;
        smp_valid = 1'b1; smp_x = 8'd0; smp_y = 8'd30; smp_z = 8'd0;
        #1 d = reg_rdata;
        @(posedge clk); @(negedge clk);
        reg_re = 1'b0; smp_valid = 1'b0;
        chk("R13 old value on read", d, 8'h42);
        chk("R13 irq after clear", {7'd0, irq}, 8'h01);
        rd(2'd1, d); chk("R13 new event captured", d, 8'h48);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_compare();
        t_combine();
        t_dur_reset();
        t_dur_dec();
        t_strobe();
        t_saturate();
        t_latch();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule